// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous 16-bit Static RAM

This block sits between a synchronous host and one asynchronous 64K x 16 static RAM. The host hands over one word request at a time. A request carries a write flag, a 16-bit word address, a 16-bit write word and a 2-bit byte enable. The controller turns each request into a timed sequence on the RAM's active-low strobes: chip select, write enable, output enable, and the lower-byte and upper-byte strobes. It also drives the address bus and the data bus. The data bus is split into an output word, an output-enable and an input word, and the pad ring or the bench resolves them.

The lengths of the access windows are counted in clock cycles. They come from parameters that give the clock period and the RAM's access time and write pulse in picoseconds, plus a safety margin of whole cycles. With the defaults (100 MHz, one cycle of margin), a read holds output enable low for 2 cycles and a write holds write enable low for 2 cycles.

During a write, output enable stays high so that the shorter write pulse of the RAM applies. The controller drives the data bus for one setup cycle and then for the write pulse, and releases it on the edge where write enable rises. When an access changes direction (a read after a write, or a write after a read), the controller inserts an idle cycle with the bus released.

Host side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the host must hold the request and its fields stable until it is taken. Read data returns on a one-cycle `rsp_valid` pulse. There is no back-pressure on responses, and at most one access is ever in flight.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving it, all five RAM strobes are high, `mem_dq_oe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: A write runs as one setup cycle followed by WE_CYC consecutive cycles with `mem_we_n` low (2 by default). In the setup cycle, `mem_cs_n` is low, `mem_we_n` is high and `mem_dq_o` carries the write word with `mem_dq_oe` high.
- R3: `mem_oe_n` is high in every cycle where `mem_we_n` is low.
- R4: `mem_dq_oe` is high only while `mem_cs_n` is low and `mem_oe_n` is high. It falls on the same edge where `mem_we_n` rises. The RAM and the controller never drive the bus in the same cycle.
- R5: During an access, `mem_lb_n` is low exactly when byte enable bit 0 is set, and `mem_ub_n` is low exactly when bit 1 is set. Bit 0 maps to data bits 7:0 and bit 1 maps to bits 15:8. A write changes only the enabled lanes of the stored word.
- R6: A read holds `mem_cs_n` and `mem_oe_n` low for RD_CYC consecutive cycles (2 by default). The bus is sampled in the last of those cycles, and `rsp_valid` pulses for exactly one cycle, the cycle after. `rsp_rdata` carries the enabled lanes and zero in the lanes that were not enabled.
- R7: When an access runs in the opposite direction to the previous one, at least 2 cycles with `mem_cs_n` high separate the two accesses.
- R8: `req_ready` is low for the whole of every access. Each accepted request produces exactly one RAM access, and each read produces exactly one response, in request order.
- R9: While `mem_cs_n` is high, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are high and `mem_dq_oe` is low.
- R10: `mem_addr` equals the accepted address and stays unchanged for every cycle in which `mem_cs_n` is low.
- R11: A request with byte enable 00 still runs its access, with both lane strobes high. As a write it leaves memory unchanged. As a read it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | RAM lower-byte strobe, active low |
| mem_ub_n | output | 1 | RAM upper-byte strobe, active low |
| mem_addr | output | 16 | RAM address bus |
| mem_dq_o | output | 16 | Data bus value driven by the controller |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | 16 | Data bus value seen at the pads |

## Verification
The hardest situation to reach from the ports is a direction change right at the first cycle the controller becomes idle again. This is where a missing turnaround would let the controller's driver and the RAM's outputs overlap. The bench reaches it by holding `req_valid` high continuously, so each new request is taken on the first ready cycle, and by drawing the direction at random so that read/write alternations happen often back to back. A model RAM flags any cycle where both sides drive the bus. Directed cases add the empty byte enable, the single-lane masks, and the top and bottom addresses.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TURN   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_READ   = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic lb_n;
    logic ub_n;
    logic dq_oe;
  } bus_ctl_t;

  // Whole cycles needed to cover a time in picoseconds.
  function automatic int unsigned cycles_for(int unsigned t_ps, int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 2,
  parameter int RD_CYC = 2,
  parameter int WE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  input  logic              tmr_expired,
  output logic              capture,
  output logic [1:0]        op_be,
  output bus_ctl_t          ctl,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata
);
  seq_state_t state_q, state_nxt;
  logic       op_write_q, have_prev_q, prev_write_q;
  logic       accept;
  logic [1:0] be_nxt;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign be_nxt    = accept ? req_be : op_be;

  function automatic bus_ctl_t ctl_for(seq_state_t s, logic [1:0] be);
    bus_ctl_t c;
    c.cs_n = 1'b1; c.we_n = 1'b1; c.oe_n = 1'b1;
    c.lb_n = 1'b1; c.ub_n = 1'b1; c.dq_oe = 1'b0;
    if (s == ST_WSETUP || s == ST_WPULSE || s == ST_READ) begin
      c.cs_n = 1'b0;
      c.lb_n = !be[0];
      c.ub_n = !be[1];
    end
    if (s == ST_WSETUP || s == ST_WPULSE) c.dq_oe = 1'b1;
    if (s == ST_WPULSE) c.we_n = 1'b0;
    if (s == ST_READ)   c.oe_n = 1'b0;
    return c;
  endfunction

  always_comb begin
    state_nxt = state_q;
    capture   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        if (have_prev_q && (prev_write_q != req_write)) state_nxt = ST_TURN;
        else state_nxt = req_write ? ST_WSETUP : ST_READ;
      end
      ST_TURN:   state_nxt = op_write_q ? ST_WSETUP : ST_READ;
      ST_WSETUP: state_nxt = ST_WPULSE;
      ST_WPULSE: if (tmr_expired) state_nxt = ST_IDLE;
      ST_READ: if (tmr_expired) begin
        state_nxt = ST_IDLE;
        capture   = 1'b1;
      end
      default:   state_nxt = ST_IDLE;
    endcase
  end

  // Timer is armed on entry to a timed window.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_nxt == ST_WPULSE && state_q != ST_WPULSE) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(WE_CYC - 1);
    end else if (state_nxt == ST_READ && state_q != ST_READ) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(RD_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      op_write_q   <= 1'b0;
      have_prev_q  <= 1'b0;
      prev_write_q <= 1'b0;
      op_be        <= '0;
      op_addr      <= '0;
      op_wdata     <= '0;
      ctl          <= ctl_for(ST_IDLE, 2'b00);
    end else begin
      state_q <= state_nxt;
      ctl     <= ctl_for(state_nxt, be_nxt);
      if (accept) begin
        op_write_q   <= req_write;
        have_prev_q  <= 1'b1;
        prev_write_q <= req_write;
        op_be        <= req_be;
        op_addr      <= req_addr;
        op_wdata     <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [1:0]        lane_en,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int LANE_W = DATA_W / 2;

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= capture;
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        rsp_rdata[g*LANE_W +: LANE_W] <= '0;
      else if (capture)
        rsp_rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CLK_PS     = 10000,
  parameter int T_ACC_PS   = 10000,
  parameter int T_WP_PS    = 7000,
  parameter int MARGIN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RD_CYC = int'(cycles_for(T_ACC_PS, CLK_PS)) + MARGIN_CYC;
  localparam int WE_CYC = int'(cycles_for(T_WP_PS, CLK_PS)) + MARGIN_CYC;
  localparam int MAX_CYC = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int CNT_W  = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_load, tmr_expired, capture;
  logic [CNT_W-1:0] tmr_val;
  logic [1:0]       op_be;
  bus_ctl_t         ctl;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  sram_access_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .RD_CYC(RD_CYC), .WE_CYC(WE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_expired(tmr_expired),
    .capture(capture), .op_be(op_be), .ctl(ctl),
    .op_addr(mem_addr), .op_wdata(mem_dq_o)
  );

  sram_read_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .capture(capture), .lane_en(op_be),
    .dq_i(mem_dq_i), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign mem_cs_n  = ctl.cs_n;
  assign mem_we_n  = ctl.we_n;
  assign mem_oe_n  = ctl.oe_n;
  assign mem_lb_n  = ctl.lb_n;
  assign mem_ub_n  = ctl.ub_n;
  assign mem_dq_oe = ctl.dq_oe;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  logic [1:0] idle_run;
  logic       seen_access, last_was_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_run       <= 2'd0;
      seen_access    <= 1'b0;
      last_was_write <= 1'b0;
    end else if (mem_cs_n) begin
      if (idle_run != 2'd3) idle_run <= idle_run + 2'd1;
    end else begin
      idle_run       <= 2'd0;
      seen_access    <= 1'b1;
      last_was_write <= mem_dq_oe;
    end
  end

  p_we_after_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && !$past(mem_cs_n)));

  p_oe_high_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_drive_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n));

  p_release_at_we_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe);

  p_rsp_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(mem_cs_n) && seen_access && (mem_dq_oe != last_was_write))
      |-> (idle_run >= 2'd2));

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RD_CYC = 2;
  localparam int WE_CYC = 2;
  localparam int N_RANDOM = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_addr, mem_dq_o, mem_dq_i;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] model_mem [256];
  logic [15:0] ref_mem   [256];
  logic [15:0] exp_q [$];
  int reads_issued = 0, rsp_seen = 0, reqs_issued = 0, accesses_seen = 0;

  logic [15:0] cur_addr, cur_wdata;
  logic [1:0]  cur_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Model RAM output: enabled lanes read the array, others float to a pattern.
  logic ram_drive_lo, ram_drive_hi;
  assign ram_drive_lo = !mem_cs_n && mem_we_n && !mem_oe_n && !mem_lb_n;
  assign ram_drive_hi = !mem_cs_n && mem_we_n && !mem_oe_n && !mem_ub_n;
  assign mem_dq_i[7:0]  = ram_drive_lo ? model_mem[mem_addr[7:0]][7:0]  : 8'hA5;
  assign mem_dq_i[15:8] = ram_drive_hi ? model_mem[mem_addr[7:0]][15:8] : 8'h5A;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Issue one request; valid is held until the controller takes it.
  task automatic do_req(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    logic [15:0] m;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    cur_addr = a; cur_wdata = d; cur_be = be;
    m = lane_mask(be);
    if (wr) ref_mem[a[7:0]] = (ref_mem[a[7:0]] & ~m) | (d & m);
    else begin
      exp_q.push_back(ref_mem[a[7:0]] & m);
      reads_issued++;
    end
    reqs_issued++;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Cycle monitor, sampled away from the active edge.
  int  we_run = 0, oe_run = 0, idle_run = 0;
  bit  have_prev = 0, last_dir = 0, prev_cs_n = 1, prev_setup = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!mem_cs_n) begin
        chk(mem_addr == cur_addr, "R10 address", mem_addr, cur_addr);
        chk({mem_ub_n, mem_lb_n} == ~cur_be, "R5 lane strobes",
            {mem_ub_n, mem_lb_n}, ~cur_be);
        chk(!req_ready, "R8 ready low while busy", req_ready, 0);
        if (prev_cs_n) begin
          accesses_seen++;
          if (have_prev && (mem_dq_oe != last_dir))
            chk(idle_run >= 2, "R7 turnaround", idle_run, 2);
          have_prev = 1;
          last_dir  = mem_dq_oe;
        end
        idle_run = 0;
      end else begin
        idle_run++;
        chk(mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
            "R9 idle strobes", {mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
            5'b11110);
      end
      chk(!(mem_dq_oe && (ram_drive_lo || ram_drive_hi)), "R4 bus contention",
          {mem_dq_oe, ram_drive_lo, ram_drive_hi}, 0);
      if (mem_dq_oe) chk(!mem_cs_n && mem_oe_n, "R4 drive window",
                         {mem_cs_n, mem_oe_n}, 2'b01);
      if (!mem_we_n) begin
        chk(mem_oe_n, "R3 oe high in write", mem_oe_n, 1);
        if (we_run == 0) chk(prev_setup, "R2 setup before pulse", prev_setup, 1);
        we_run++;
        if (mem_dq_oe) begin
          if (!mem_lb_n) model_mem[mem_addr[7:0]][7:0]  = mem_dq_o[7:0];
          if (!mem_ub_n) model_mem[mem_addr[7:0]][15:8] = mem_dq_o[15:8];
        end
      end else if (we_run > 0) begin
        chk(we_run == WE_CYC, "R2 pulse length", we_run, WE_CYC);
        chk(!mem_dq_oe, "R4 release at we rise", mem_dq_oe, 0);
        we_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin
        chk(oe_run == RD_CYC, "R6 read window", oe_run, RD_CYC);
        oe_run = 0;
      end
      if (rsp_valid) begin
        rsp_seen++;
        if (exp_q.size() == 0) chk(0, "R8 unexpected response", rsp_seen, reads_issued);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R6 R5 R11 read data", rsp_rdata, e);
        end
      end
      prev_setup = !mem_cs_n && mem_we_n && mem_dq_oe && (mem_dq_o == cur_wdata);
      prev_cs_n  = mem_cs_n;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin model_mem[i] = '0; ref_mem[i] = '0; end
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1: state under reset and on release
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1 strobes in reset",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1F);
    chk(!mem_dq_oe && !rsp_valid && req_ready, "R1 idle in reset",
        {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_dq_oe && !rsp_valid && req_ready && mem_cs_n, "R1 after release",
        {mem_dq_oe, rsp_valid, req_ready, mem_cs_n}, 4'b0011);

    // Directed corners
    do_req(1, 16'h0000, 16'h1234, 2'b11);
    do_req(1, 16'hFFFF, 16'hBEEF, 2'b11);
    do_req(0, 16'h0000, 16'h0, 2'b11);
    do_req(0, 16'hFFFF, 16'h0, 2'b11);
    do_req(1, 16'h0000, 16'hAAAA, 2'b01);   // R5 lower only
    do_req(0, 16'h0000, 16'h0, 2'b11);      // expect 12AA
    do_req(1, 16'h0000, 16'h5555, 2'b10);   // R5 upper only
    do_req(0, 16'h0000, 16'h0, 2'b11);      // expect 55AA
    do_req(1, 16'hFFFF, 16'h0000, 2'b00);   // R11 empty write
    do_req(0, 16'hFFFF, 16'h0, 2'b11);      // expect BEEF
    do_req(0, 16'hFFFF, 16'h0, 2'b00);      // R11 empty read -> 0
    do_req(0, 16'hFFFF, 16'h0, 2'b01);      // R6 lower lane only
    do_req(0, 16'hFFFF, 16'h0, 2'b10);      // R6 upper lane only

    // Random mix, small address window so reads hit written data
    for (int n = 0; n < N_RANDOM; n++) begin
      logic [15:0] a;
      a = {16'($urandom)} & 16'hFF0F;
      do_req(1'($urandom), a, 16'($urandom), 2'($urandom));
    end

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads answered", exp_q.size(), 0);
    chk(rsp_seen == reads_issued, "R8 response count", rsp_seen, reads_issued);
    chk(accesses_seen == reqs_issued, "R8 one access per request", accesses_seen, reqs_issued);
    finish_run();
  end
endmodule